// File: doc/BRIEF.md
# Serial Register-Access Slave

This block lets a host controller reach a bank of 32 registers, each 25 bits wide, over a four-wire serial link. Every access is one 32-bit full-duplex frame, sent most significant bit first. The top bit of the frame picks the operation: 1 writes and 0 reads. The next five bits give the register number, bit 25 is a spare position, and the low 25 bits carry the payload. A write frame stores its payload into the addressed register when the frame completes. In every frame the block shifts the addressed register's contents back to the host during the last 25 bit times. This means a read frame returns data in the same chip-select window.

The serial pins are oversampled by the block's system clock through synchronizers. The chip-select polarity is fixed at build time. A parallel port lets neighbouring logic read any register combinationally and write one register per cycle. Register 0 holds interrupt status and register 1 holds the interrupt mask. Both are reached through the same frame format as every other register.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 32 bits, most significant bit first, in SPI mode 0: MOSI is sampled on rising SCLK and MISO changes on falling SCLK. Frame bit 31 = 1 is a write, bits 30:26 are the register number, and bits 24:0 are the payload. A completed write frame stores the payload into the addressed register.
- R2: Frame bit 25 is ignored on writes. Only bits 24:0 reach the register.
- R3: In every frame, read or write, MISO carries the addressed register's contents as they were when the address arrived. The value is sent MSB first in frame bit times 24:0, and frame bit times 31:25 return zero.
- R4: A read frame (bit 31 = 0) leaves every register unchanged.
- R5: If chip select is released before all 32 bits have arrived (for example after 20 or 31 bits), the frame is discarded and no register changes.
- R6: After reset, register 1 (the mask) reads all ones (0x1FFFFFF) and every other register reads zero.
- R7: Chip-select polarity is set by the parameter CS_ACTIVE_LOW: 1 means active low and 0 means active high. An instance whose select is inactive ignores the serial traffic.
- R8: par_rdata shows the register chosen by par_addr combinationally. With par_we high at a clock edge, par_wdata is stored into that register and is visible from the next cycle.
- R9: Any SCLK edges after the 32nd within one chip-select window are ignored and cause no second write.
- R10: MISO is held low while chip select is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs | input | 1 | Chip select, polarity set by CS_ACTIVE_LOW |
| spi_miso | output | 1 | Serial data to the host |
| par_addr | input | 5 | Register number for the parallel port |
| par_we | input | 1 | Parallel write strobe |
| par_wdata | input | 25 | Parallel write data |
| par_rdata | output | 25 | Contents of the register chosen by par_addr |

## Verification
A wrong bit counter shows up within the same frame. It causes a missed or doubled write, or a MISO bit stream shifted by one position, and the very next read-back on either port exposes it. A wrong captured address or a stale read snapshot changes the 25 data bits the host receives in that frame. A corrupted register is visible on par_rdata one cycle after the faulty write. The reset value of the mask register is visible before any frame is sent.

// File: rtl/spi_regs_pkg.sv
// Shared frame geometry for the serial register slave.
// Assumes a fixed 32-bit frame: op flag, 5-bit address, spare bit, 25-bit payload.
package spi_regs_pkg;
    localparam int FRAME_W   = 32;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 25;
    localparam int OP_POS    = FRAME_W - 1;
    localparam int ADDR_LSB  = FRAME_W - 1 - ADDR_W;
    localparam int NUM_REGS  = 1 << ADDR_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);
    localparam int HDR_BITS  = 1 + ADDR_W;
    localparam int DATA_FROM = FRAME_W - DATA_W;
endpackage

// File: rtl/spi_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is an independent level; no multi-bit coherency implied.
module spi_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
// Serial frame engine: synchronizes the pins and detects SCLK edges.
// It shifts the frame in and drives the read-back bits out.
// Assumes SCLK idles low and each SCLK half period spans at least
// SYNC_STAGES + 3 system clocks.
module spi_frame_shifter
    import spi_regs_pkg::*;
#(
    parameter bit CS_ACTIVE_LOW = 1'b1,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              cs_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic [ADDR_W-1:0] hdr_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              miso_o,
    output logic              cs_act_o,
    output logic [CNT_W-1:0]  bit_cnt_o
);
    localparam logic [2:0] SYNC_RST = {CS_ACTIVE_LOW, 2'b00};

    logic [2:0]         pins_s;
    logic               sclk_q, rise, fall, cs_act;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;
    logic [DATA_W-1:0]  snap;
    logic               cap_q, fire_q, miso_q;
    logic [CNT_W-1:0]   tap;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_i, sclk_i, mosi_i}),
        .q     (pins_s)
    );

    assign cs_act = CS_ACTIVE_LOW ? ~pins_s[2] : pins_s[2];
    assign rise   = cs_act &  pins_s[1] & ~sclk_q;
    assign fall   = cs_act & ~pins_s[1] &  sclk_q;
    assign tap    = CNT_W'(FRAME_W - 1) - cnt;

    // Remember the previous synchronized SCLK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= pins_s[1];
    end

    // Count and shift in frame bits; stop counting once the frame is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sh  <= '0;
        end else if (!cs_act) begin
            cnt <= '0;
        end else if (rise && cnt != CNT_W'(FRAME_W)) begin
            sh  <= {sh[FRAME_W-2:0], pins_s[0]};
            cnt <= cnt + 1'b1;
        end
    end

    // Pulse once the header is in, and once a full write frame is in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= 1'b0;
            fire_q <= 1'b0;
        end else begin
            cap_q  <= rise && cnt == CNT_W'(HDR_BITS - 1);
            fire_q <= rise && cnt == CNT_W'(FRAME_W - 1) && sh[FRAME_W-2];
        end
    end

    // Snapshot the addressed register right after the address arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)     snap <= '0;
        else if (cap_q) snap <= rd_word_i;
    end

    // Drive MISO on falling SCLK: zeros in the header, then the snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) miso_q <= 1'b0;
        else if (fall) begin
            if (cnt >= CNT_W'(DATA_FROM) && cnt < CNT_W'(FRAME_W))
                miso_q <= snap[tap[$clog2(DATA_W)-1:0]];
            else
                miso_q <= 1'b0;
        end
    end

    assign hdr_addr_o = sh[ADDR_W-1:0];
    assign wr_en_o    = fire_q;
    assign wr_addr_o  = sh[ADDR_LSB +: ADDR_W];
    assign wr_data_o  = sh[DATA_W-1:0];
    assign miso_o     = miso_q;
    assign cs_act_o   = cs_act;
    assign bit_cnt_o  = cnt;
endmodule

// File: rtl/spi_reg_bank.sv
// Register bank with one serial write port, one parallel write port
// and two combinational read ports. The serial write wins on an address clash.
// Assumes the mask register resets to all ones and every other register to zero.
module spi_reg_bank
    import spi_regs_pkg::*;
#(
    parameter int MASK_REG = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_we,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic              p_we,
    input  logic [ADDR_W-1:0] p_addr,
    input  logic [DATA_W-1:0] p_wdata,
    input  logic [ADDR_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    // Reset values and prioritized writes for every register.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n)
                mem[i] <= (i == MASK_REG) ? '1 : '0;
            else if (s_we && s_addr == ADDR_W'(i))
                mem[i] <= s_wdata;
            else if (p_we && p_addr == ADDR_W'(i))
                mem[i] <= p_wdata;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/spi_reg_slave.sv
// Top of the serial register slave: frame engine plus register bank.
// Assumes SPI mode 0 and a host that sends exactly one frame per select window.
module spi_reg_slave
    import spi_regs_pkg::*;
#(
    parameter bit CS_ACTIVE_LOW = 1'b1,
    parameter int SYNC_STAGES   = 2,
    parameter int MASK_REG      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_cs,
    output logic              spi_miso,
    input  logic [ADDR_W-1:0] par_addr,
    input  logic              par_we,
    input  logic [DATA_W-1:0] par_wdata,
    output logic [DATA_W-1:0] par_rdata
);
    logic [ADDR_W-1:0] hdr_addr;
    logic [DATA_W-1:0] hdr_word;
    logic              spi_we;
    logic [ADDR_W-1:0] spi_waddr;
    logic [DATA_W-1:0] spi_wdata;
    logic              cs_act;
    logic [CNT_W-1:0]  bit_cnt;

    spi_frame_shifter #(
        .CS_ACTIVE_LOW (CS_ACTIVE_LOW),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (spi_sclk),
        .mosi_i     (spi_mosi),
        .cs_i       (spi_cs),
        .rd_word_i  (hdr_word),
        .hdr_addr_o (hdr_addr),
        .wr_en_o    (spi_we),
        .wr_addr_o  (spi_waddr),
        .wr_data_o  (spi_wdata),
        .miso_o     (spi_miso),
        .cs_act_o   (cs_act),
        .bit_cnt_o  (bit_cnt)
    );

    spi_reg_bank #(.MASK_REG(MASK_REG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_we    (spi_we),
        .s_addr  (spi_waddr),
        .s_wdata (spi_wdata),
        .p_we    (par_we),
        .p_addr  (par_addr),
        .p_wdata (par_wdata),
        .ra_addr (hdr_addr),
        .ra_data (hdr_word),
        .rb_addr (par_addr),
        .rb_data (par_rdata)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
// Checker bound to the serial register slave; it watches the frame engine
// and the parallel port. It assumes synchronous active-low reset.
module spi_reg_slave_chk
    import spi_regs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              spi_we,
    input logic [ADDR_W-1:0] spi_waddr,
    input logic              spi_miso,
    input logic              par_we,
    input logic [ADDR_W-1:0] par_addr,
    input logic [DATA_W-1:0] par_wdata,
    input logic [DATA_W-1:0] par_rdata
);
    // R10: an idle select silences MISO on the next cycle.
    p_miso_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !spi_miso);

    // R5: releasing select throws away any partial bit count.
    p_drop_partial_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> bit_cnt == '0);

    // R1: a serial write only happens with a complete frame.
    p_full_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_we |-> bit_cnt == CNT_W'(FRAME_W));

    // R9: the bit counter never runs past one frame.
    p_cnt_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W));

    // R8: an uncontested parallel write shows up the next cycle.
    p_par_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (par_we && !(spi_we && spi_waddr == par_addr)) |=>
        ((par_addr != $past(par_addr)) || (par_rdata == $past(par_wdata))));
endmodule

bind spi_reg_slave spi_reg_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_act    (cs_act),
    .bit_cnt   (bit_cnt),
    .spi_we    (spi_we),
    .spi_waddr (spi_waddr),
    .spi_miso  (spi_miso),
    .par_we    (par_we),
    .par_addr  (par_addr),
    .par_wdata (par_wdata),
    .par_rdata (par_rdata)
);

// File: tb/spi_reg_slave_tb.sv
// Self-checking bench: a vector table of frames, then directed corner tests.
module spi_reg_slave_tb;
    localparam int HALF = 8;
    localparam int NV   = 10;
    // {op, addr[4:0], frame bits 25:0, expected MISO data[24:0]}
    localparam logic [56:0] VEC [NV] = '{
        {1'b0, 5'd1,  26'h0000000, 25'h1FFFFFF},
        {1'b1, 5'd3,  26'h3234567, 25'h0000000},
        {1'b0, 5'd3,  26'h2000000, 25'h1234567},
        {1'b1, 5'd31, 26'h0AAAAAA, 25'h0000000},
        {1'b1, 5'd31, 26'h1555555, 25'h0AAAAAA},
        {1'b0, 5'd31, 26'h0000000, 25'h1555555},
        {1'b0, 5'd0,  26'h0000000, 25'h0000000},
        {1'b1, 5'd1,  26'h0000000, 25'h1FFFFFF},
        {1'b0, 5'd1,  26'h0000000, 25'h0000000},
        {1'b1, 5'd0,  26'h1000001, 25'h0000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, cs_h = 1'b0;
    logic        miso_lo, miso_hi;
    logic [4:0]  par_addr = '0, par_addr_h = '0;
    logic        par_we = 1'b0;
    logic [24:0] par_wdata = '0;
    logic [24:0] par_rdata, par_rdata_h;
    logic [31:0] rx;
    int          n_cmp = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    spi_reg_slave u_dut (
        .clk (clk), .rst_n (rst_n), .spi_sclk (sclk), .spi_mosi (mosi),
        .spi_cs (cs_n), .spi_miso (miso_lo), .par_addr (par_addr),
        .par_we (par_we), .par_wdata (par_wdata), .par_rdata (par_rdata)
    );

    spi_reg_slave #(.CS_ACTIVE_LOW(1'b0)) u_dut_ah (
        .clk (clk), .rst_n (rst_n), .spi_sclk (sclk), .spi_mosi (mosi),
        .spi_cs (cs_h), .spi_miso (miso_hi), .par_addr (par_addr_h),
        .par_we (1'b0), .par_wdata (25'h0), .par_rdata (par_rdata_h)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_frame(input bit use_hi, input logic [31:0] tx, input int nbits,
                             output logic [31:0] rxo);
        rxo = '0;
        @(negedge clk);
        if (use_hi) cs_h = 1'b1; else cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            mosi = (i < 32) ? tx[31-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (i < 32) rxo[31-i] = use_hi ? miso_hi : miso_lo;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        cs_h = 1'b0;
        mosi = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: reset values; R10: MISO idle low.
        par_addr = 5'd0;  #1 check("R6 reg0 reset", 32'(par_rdata), 32'h0);
        par_addr = 5'd1;  #1 check("R6 mask reset", 32'(par_rdata), 32'h1FFFFFF);
        par_addr = 5'd17; #1 check("R6 reg17 reset", 32'(par_rdata), 32'h0);
        check("R10 miso idle", 32'(miso_lo), 32'h0);
        check("R10 miso idle ah", 32'(miso_hi), 32'h0);

        // Vector table: R1 R2 R3 R4.
        for (int v = 0; v < NV; v++) begin
            logic        op;
            logic [4:0]  ad;
            logic [25:0] dt;
            logic [24:0] ex;
            op = VEC[v][56];
            ad = VEC[v][55:51];
            dt = VEC[v][50:25];
            ex = VEC[v][24:0];
            spi_frame(1'b0, {op, ad, dt}, 32, rx);
            check("R3 header bits zero", 32'(rx[31:25]), 32'h0);
            check("R3 returned data", 32'(rx[24:0]), 32'(ex));
            par_addr = ad;
            @(negedge clk);
            if (op) check("R1 R2 write stored", 32'(par_rdata), 32'(dt[24:0]));
            else    check("R4 read keeps register", 32'(par_rdata), 32'(ex));
        end

        // R5: partial frames (20 and 31 bits) are discarded.
        spi_frame(1'b0, {1'b1, 5'd7, 26'h0000777}, 32, rx);
        spi_frame(1'b0, {1'b1, 5'd7, 26'h1111111}, 20, rx);
        par_addr = 5'd7; #1 check("R5 20-bit frame dropped", 32'(par_rdata), 32'h777);
        spi_frame(1'b0, {1'b1, 5'd7, 26'h1111111}, 31, rx);
        par_addr = 5'd7; #1 check("R5 31-bit frame dropped", 32'(par_rdata), 32'h777);

        // R9: extra SCLK edges after 32 bits do nothing.
        spi_frame(1'b0, {1'b1, 5'd5, 26'h0ABCDEF}, 40, rx);
        par_addr = 5'd5; #1 check("R9 extra edges ignored", 32'(par_rdata), 32'h0ABCDEF);
        check("R10 miso low after frame", 32'(miso_lo), 32'h0);
        spi_frame(1'b0, {1'b0, 5'd5, 26'h0}, 32, rx);
        check("R9 readback after long frame", rx, 32'h00ABCDEF);

        // R8: parallel write and combinational read.
        @(negedge clk);
        par_addr = 5'd9; par_wdata = 25'h0F0F0F0; par_we = 1'b1;
        @(negedge clk);
        par_we = 1'b0;
        check("R8 parallel write", 32'(par_rdata), 32'h0F0F0F0);
        par_addr = 5'd3; #1 check("R8 combinational read", 32'(par_rdata), 32'h1234567);
        spi_frame(1'b0, {1'b0, 5'd9, 26'h0}, 32, rx);
        check("R8 serial sees parallel write", rx, 32'h000F0F0F0);

        // R7: active-high instance works; the active-low one ignores it.
        spi_frame(1'b1, {1'b1, 5'd4, 26'h0000ABC}, 32, rx);
        spi_frame(1'b1, {1'b0, 5'd4, 26'h0}, 32, rx);
        check("R7 active-high readback", rx, 32'h00000ABC);
        par_addr_h = 5'd4; par_addr = 5'd4;
        #1 check("R7 active-high stored", 32'(par_rdata_h), 32'hABC);
        check("R7 deselected instance untouched", 32'(par_rdata), 32'h0);

        finish_run();
    end
endmodule